// File: doc/BRIEF.md
# Double-Buffered 16-bit Pulse-Width Generator

This block drives a single pulse-width-modulated output. A 16-bit counter runs freely from a divided copy of the system clock. Each period lasts 2^16 counter ticks. The output holds an initial level until the counter matches the programmed width. It then flips to the opposite level, and it returns to the initial level when the counter wraps. Each wrap produces a one-cycle period interrupt.

The host sets the width over an 8-bit bus, writing the low byte first and then the high byte. A high byte that completes a pair commits the 16-bit value. While the generator runs, the value waits in a buffer and moves into the active width register at the next wrap. While the generator is stopped, the value moves there at once. Readback always returns the active width.

When the generator stops, the pin keeps its current level. While it is stopped, the host can force the pin through the level flip-flop, which also sets the polarity for the next run.

Top module: `bufpwm16`

## Requirements
- R1: While reset is held and on the first cycle after it, `pwm_out` is 0, `period_irq` is 0 and `rd_width` is 0.
- R2: The tick interval in system clocks is 2^e. `div_sel` picks e: value 0 gives `DIV_E0`, 1 gives `DIV_E1`, 2 gives `DIV_E2` and 3 gives `DIV_E3`. Setting `div_slow` adds 1 to e. One period is 2^`CNT_W` ticks, so `period_irq` pulses every 2^(e+`CNT_W`) clocks.
- R3: `period_irq` is high for exactly one cycle per counter wrap, and only while running.
- R4: During a period, `pwm_out` equals the level flip-flop while the counter is below the active width. It is the inverse from the cycle after the counter reaches the width, and it returns to the flip-flop level after the wrap.
- R5: A width committed while running leaves `rd_width` unchanged. It becomes active, and visible on `rd_width`, at the edge that raises `period_irq`.
- R6: A width committed while stopped appears on `rd_width` on the next cycle.
- R7: A high-byte strobe commits only if a low-byte strobe came before it since the last commit. A lone high byte, or a low byte with no high byte after it, leaves `rd_width` unchanged. The committed value is {high byte, low byte}, truncated to `CNT_W` bits.
- R8: While stopped, `pwm_out` keeps the level it had at the stop, unless the level flip-flop is written.
- R9: A level write while stopped sets the flip-flop and drives `pwm_out` to the written value on the next cycle. A level write while running is ignored.
- R10: A 0-to-1 change on `run` clears the counter and the prescaler. The first `period_irq` rises exactly 2^(e+`CNT_W`) clocks after the starting edge.
- R11: A commit on the same edge as a wrap is not transferred at that wrap. It waits for the following wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 runs the generator, 0 stops it |
| div_sel | input | 2 | Prescaler tap select |
| div_slow | input | 1 | Halves the selected tick rate |
| wr_lo | input | 1 | Low-byte width strobe |
| wr_hi | input | 1 | High-byte width strobe (commits a pair) |
| wr_data | input | 8 | Width byte |
| lvl_wr | input | 1 | Level flip-flop write strobe |
| lvl_data | input | 1 | Value for the level flip-flop |
| rd_width | output | 16 | Active width readback |
| pwm_out | output | 1 | Pulse output |
| period_irq | output | 1 | One-cycle pulse at each counter wrap |

## Verification
The bench aims a high-byte commit at the exact wrap edge. A design that transferred on that edge would show the new width one period early. It also times the first interrupt after a start, which exposes a prescaler or counter that is not cleared. Lone-byte writes are sent while stopped, where any premature commit would show at once on readback. Level writes are sent both while running and while stopped: a design that took the running write would flip the polarity of the next period, and a design that let the pin move while stopped would lose the held level.

// File: rtl/bpwm_pkg.sv
// Package: shared types and helpers for the buffered PWM generator.
// Assumes the four divider exponents are passed in from the top parameters.
package bpwm_pkg;

    // Prescaler tap codes as seen on div_sel.
    typedef enum logic [1:0] {
        TAP_SLOWEST = 2'd0,
        TAP_SLOW    = 2'd1,
        TAP_FAST    = 2'd2,
        TAP_FASTEST = 2'd3
    } tap_e;

    // Returns the tick exponent for a tap code, plus one when div_slow is set.
    function automatic int unsigned tick_exp(
        input logic [1:0]  sel,
        input logic        slow,
        input int unsigned e0,
        input int unsigned e1,
        input int unsigned e2,
        input int unsigned e3
    );
        int unsigned e;
        case (tap_e'(sel))
            TAP_SLOWEST: e = e0;
            TAP_SLOW:    e = e1;
            TAP_FAST:    e = e2;
            default:     e = e3;
        endcase
        return e + (slow ? 1 : 0);
    endfunction

endpackage

// File: rtl/bpwm_prescaler.sv
// Module: bpwm_prescaler
// Divides the system clock into a single-cycle tick every 2^e clocks.
// Assumes DIV_E0 is the largest exponent. The count is held at zero while
// stopped and is cleared on the start cycle, so the first tick comes 2^e
// edges after the start edge.
module bpwm_prescaler
    import bpwm_pkg::*;
#(
    parameter int unsigned DIV_E0 = 11,
    parameter int unsigned DIV_E1 = 7,
    parameter int unsigned DIV_E2 = 5,
    parameter int unsigned DIV_E3 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       start,
    input  logic [1:0] div_sel,
    input  logic       div_slow,
    output logic       tick
);

    localparam int unsigned PRE_W = DIV_E0 + 2;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    // Terminal count for the selected tap.
    always_comb begin
        limit = PRE_W'((64'd1 << tick_exp(div_sel, div_slow,
                        DIV_E0, DIV_E1, DIV_E2, DIV_E3)) - 64'd1);
    end

    // A tap change while running must never strand the count above the limit.
    assign at_limit = (pre_cnt >= limit);
    assign tick     = run & ~start & at_limit;

    // Prescaler count: cleared when stopped, on start, and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || start || at_limit) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bpwm_width_regs.sv
// Module: bpwm_width_regs
// Byte-wise width programming with a pending buffer and an active shadow.
// A high byte commits only after a low byte. A commit while stopped loads the
// shadow directly. A commit while running waits for a wrap that does not
// coincide with a commit.
module bpwm_width_regs #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] shadow
);

    logic [7:0]       lo_hold;
    logic             lo_valid;
    logic [CNT_W-1:0] buf_q;
    logic             pending;
    logic             commit;
    logic [15:0]      pair;

    assign commit = wr_hi & lo_valid;
    assign pair   = {wr_data, lo_hold};

    // Low-byte holding register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_hold  <= '0;
            lo_valid <= 1'b0;
        end else if (wr_lo) begin
            lo_hold  <= wr_data;
            lo_valid <= 1'b1;
        end else if (wr_hi) begin
            lo_valid <= 1'b0;
        end
    end

    // Pending buffer: takes every running commit, drains at a clean wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            pending <= 1'b0;
        end else if (commit) begin
            buf_q   <= pair[CNT_W-1:0];
            pending <= run;
        end else if (wrap && pending) begin
            pending <= 1'b0;
        end
    end

    // Active shadow: direct load while stopped, buffered load at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (commit && !run) begin
            shadow <= pair[CNT_W-1:0];
        end else if (wrap && pending && !commit) begin
            shadow <= buf_q;
        end
    end

endmodule

// File: rtl/bpwm_core.sv
// Module: bpwm_core
// Period counter, wrap interrupt, level flip-flop and output register.
// The output follows the counter compare one cycle late. It holds while
// stopped, and only a level write may move it then.
module bpwm_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] width,
    input  logic             lvl_wr,
    input  logic             lvl_data,
    output logic             wrap,
    output logic             pwm_out,
    output logic             period_irq
);

    logic [CNT_W-1:0] cnt;
    logic             lvl;

    assign wrap = tick & (&cnt);

    // Period counter: cleared on start, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Period interrupt: one-cycle pulse after each wrap edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_irq <= 1'b0;
        end else begin
            period_irq <= wrap;
        end
    end

    // Level flip-flop: writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
        end else if (lvl_wr && !run) begin
            lvl <= lvl_data;
        end
    end

    // Output register: compare while running, hold or force while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= 1'b0;
        end else if (!run) begin
            if (lvl_wr) begin
                pwm_out <= lvl_data;
            end
        end else if (start) begin
            pwm_out <= lvl;
        end else begin
            pwm_out <= (cnt >= width) ? ~lvl : lvl;
        end
    end

endmodule

// File: rtl/bufpwm16.sv
// Module: bufpwm16 (top)
// Double-buffered PWM generator with a programmable prescaler.
// Assumes 8 < CNT_W <= 16 and DIV_E0 >= DIV_E1, DIV_E2, DIV_E3.
module bufpwm16 #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV_E0 = 11,
    parameter int unsigned DIV_E1 = 7,
    parameter int unsigned DIV_E2 = 5,
    parameter int unsigned DIV_E3 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic [1:0]  div_sel,
    input  logic        div_slow,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [7:0]  wr_data,
    input  logic        lvl_wr,
    input  logic        lvl_data,
    output logic [15:0] rd_width,
    output logic        pwm_out,
    output logic        period_irq
);

    logic             run_q;
    logic             start;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] shadow;

    // Registered run, used to find the 0-to-1 start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run;
        end
    end

    assign start    = run & ~run_q;
    assign rd_width = 16'(shadow);

    bpwm_prescaler #(
        .DIV_E0 (DIV_E0),
        .DIV_E1 (DIV_E1),
        .DIV_E2 (DIV_E2),
        .DIV_E3 (DIV_E3)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .start    (start),
        .div_sel  (div_sel),
        .div_slow (div_slow),
        .tick     (tick)
    );

    bpwm_width_regs #(
        .CNT_W (CNT_W)
    ) u_wregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .wrap    (wrap),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .shadow  (shadow)
    );

    bpwm_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .start      (start),
        .tick       (tick),
        .width      (shadow),
        .lvl_wr     (lvl_wr),
        .lvl_data   (lvl_data),
        .wrap       (wrap),
        .pwm_out    (pwm_out),
        .period_irq (period_irq)
    );

endmodule

// File: rtl/bpwm_sva.sv
// Module: bpwm_sva
// Port-level checker for bufpwm16, attached with bind below.
module bpwm_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        lvl_wr,
    input logic [15:0] rd_width,
    input logic        pwm_out,
    input logic        period_irq
);

    // R1: outputs are cleared by reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_width == 16'd0 && !period_irq && !pwm_out));

    // R3: the interrupt is a single-cycle pulse.
    a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |=> !period_irq);

    // R3: the interrupt only follows a cycle spent running.
    a_r3_irq_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> $past(run));

    // R5: while running, readback changes only together with the interrupt.
    a_r5_readback_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !period_irq) |-> $stable(rd_width));

    // R8: while stopped with no level write, the output holds.
    a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run) && !$past(lvl_wr)) |-> $stable(pwm_out));

endmodule

bind bufpwm16 bpwm_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .lvl_wr     (lvl_wr),
    .rd_width   (rd_width),
    .pwm_out    (pwm_out),
    .period_irq (period_irq)
);

// File: tb/bufpwm16_tb.sv
// Scoreboard bench for bufpwm16. The design runs with a narrow counter and
// small divider exponents so that several whole periods fit in the run.
module bufpwm16_tb;

    localparam int CW  = 10;
    localparam int NP  = 1 << CW;
    localparam int E0  = 5;
    localparam int E1  = 3;
    localparam int E2  = 2;
    localparam int E3  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  div_sel = 2'd3;
    logic        div_slow = 1'b0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic        lvl_wr = 1'b0;
    logic        lvl_data = 1'b0;
    logic [15:0] rd_width;
    logic        pwm_out;
    logic        period_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        string req;
        int    val;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    bufpwm16 #(
        .CNT_W (CW), .DIV_E0 (E0), .DIV_E1 (E1), .DIV_E2 (E2), .DIV_E3 (E3)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .run (run), .div_sel (div_sel),
        .div_slow (div_slow), .wr_lo (wr_lo), .wr_hi (wr_hi),
        .wr_data (wr_data), .lvl_wr (lvl_wr), .lvl_data (lvl_data),
        .rd_width (rd_width), .pwm_out (pwm_out), .period_irq (period_irq)
    );

    // Driver side: queue the value the requirements predict.
    task automatic push_exp(input string req, input int val);
        item_t it;
        it.req = req;
        it.val = val;
        exp_q.push_back(it);
    endtask

    // Monitor side: pop the oldest prediction and compare.
    task automatic observe(input int actual);
        item_t it;
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL scoreboard empty: actual=%0d expected=none", actual);
        end else begin
            it = exp_q.pop_front();
            if (actual != it.val) begin
                bad++;
                $display("FAIL %s: actual=%0d expected=%0d", it.req, actual, it.val);
            end
        end
    endtask

    task automatic check(input string req, input int actual, input int val);
        push_exp(req, val);
        observe(actual);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_lo(input logic [7:0] b);
        wr_lo = 1'b1; wr_data = b;
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    task automatic put_hi(input logic [7:0] b);
        wr_hi = 1'b1; wr_data = b;
        @(negedge clk);
        wr_hi = 1'b0;
    endtask

    task automatic put_lvl(input logic v);
        lvl_wr = 1'b1; lvl_data = v;
        @(negedge clk);
        lvl_wr = 1'b0;
    endtask

    // Counts edges until the interrupt is seen at a falling edge.
    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!period_irq && n < 100000);
    endtask

    initial begin
        int n;
        cyc(3);
        // R1: reset values
        check("R1 pwm", int'(pwm_out), 0);
        check("R1 irq", int'(period_irq), 0);
        check("R1 rd", int'(rd_width), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd after", int'(rd_width), 0);

        // R7: lone high byte, then lone low byte, then the pair completes
        put_hi(8'h03);
        check("R7 lone hi", int'(rd_width), 0);
        put_lo(8'h2C);
        check("R7 lone lo", int'(rd_width), 0);
        put_hi(8'h01);
        // R6: stopped commit appears on the next cycle
        check("R6 R7 commit 300", int'(rd_width), 300);

        // R10: first interrupt after start; R2: fastest tap interval
        div_sel = 2'd3; div_slow = 1'b0;
        run = 1'b1;
        wait_irq(n);
        check("R10 first irq", n, 2 * NP + 1);
        @(negedge clk);
        // R3: one-cycle pulse
        check("R3 irq drop", int'(period_irq), 0);
        wait_irq(n);
        check("R2 tap3 interval", n, 2 * NP - 1);

        // R4: output shape with level 0, then R8 hold at stop
        run = 1'b0;
        cyc(2);
        run = 1'b1;
        cyc(200);
        check("R4 before width", int'(pwm_out), 0);
        cyc(600);
        check("R4 after width", int'(pwm_out), 1);
        run = 1'b0;
        cyc(20);
        check("R8 held level", int'(pwm_out), 1);

        // R9: stopped level writes force the pin
        put_lvl(1'b0);
        check("R9 force 0", int'(pwm_out), 0);
        put_lvl(1'b1);
        check("R9 force 1", int'(pwm_out), 1);

        // R4: inverted polarity run
        run = 1'b1;
        cyc(200);
        check("R4 inv before", int'(pwm_out), 1);
        cyc(600);
        check("R4 inv after", int'(pwm_out), 0);
        // R9: running level write ignored
        put_lvl(1'b0);
        wait_irq(n);
        cyc(200);
        check("R9 running write ignored", int'(pwm_out), 1);

        // R5: running commit is buffered until the wrap
        put_lo(8'h58);
        put_hi(8'h02);
        cyc(5);
        check("R5 still old", int'(rd_width), 300);
        wait_irq(n);
        check("R5 new at irq", int'(rd_width), 600);
        cyc(800);
        check("R5 R4 below 600", int'(pwm_out), 1);
        cyc(600);
        check("R5 R4 above 600", int'(pwm_out), 0);

        // R11: commit on the wrap edge waits one more period
        wait_irq(n);
        put_lo(8'h84);
        repeat (2 * NP - 2) @(posedge clk);
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 8'h03;
        @(negedge clk);
        wr_hi = 1'b0;
        check("R11 aligned on wrap", int'(period_irq), 1);
        check("R11 not transferred", int'(rd_width), 600);
        wait_irq(n);
        check("R11 transferred next wrap", int'(rd_width), 900);

        // R2 R10: other taps and the slow bit
        run = 1'b0;
        div_sel = 2'd2; div_slow = 1'b1;
        cyc(2);
        run = 1'b1;
        wait_irq(n);
        check("R2 R10 tap2 slow", n, 8 * NP + 1);
        run = 1'b0;
        div_sel = 2'd0; div_slow = 1'b0;
        cyc(2);
        run = 1'b1;
        wait_irq(n);
        check("R2 R10 tap0", n, 32 * NP + 1);
        run = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule